// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block snoops a parallel asynchronous-SRAM style bus (active-low chip enable, write enable, output enable and a 16-bit address) and picks out a hidden command. The host gives the command as six reads in a row. The first five reads use fixed key addresses. The address of the sixth read chooses one of three commands: commit the array to nonvolatile storage, restore the array from nonvolatile storage, or turn off the automatic store. When a full series is seen, the block raises one command line for exactly one clock.

The block only watches the bus. It never stalls or alters ordinary reads, so normal read data keeps flowing during a series. The bus is sampled with the system clock. An access is counted on the falling edge of chip enable. Any write, and any read at the wrong address, breaks the series. A read at the first key address still opens a new series at once, even when that same read breaks the current one.

Top module: `seq_unlock_detector`

## Requirements
- R1: After reset is released, all three command outputs are low and the detector is idle, so the next access is treated as step 1.
- R2: A step is taken only on a high-to-low change of `bus_ce_n_i` seen at a clock edge. Cycles with chip enable high, and further cycles while chip enable stays low, neither advance nor break the series, whatever the address and write enable do.
- R3: The reads in steps 1 to 5 must be at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order. If the sixth read is then at 0x8FC0, `cmd_store_o` pulses.
- R4: If the five key reads are followed by a sixth read at 0x4C63, `cmd_recall_o` pulses.
- R5: If the five key reads are followed by a sixth read at 0x8B45, `cmd_auto_off_o` pulses.
- R6: Only address bits 14 down to 2 are compared. Bits 15, 1 and 0 have no effect on matching.
- R7: An access with `bus_we_n_i` low at any step returns the detector to idle, and no command is issued for that series. This holds even when the address matches a key.
- R8: A read at any of steps 1 to 5 whose address does not match the expected key breaks the series. The remaining keys and a final code that follow it then issue no command.
- R9: A breaking read at any of steps 2 to 5 that matches the first key, 0x4E38, is counted as step 1 of a new series.
- R10: A command pulse lasts one clock cycle, and at most one command line is high at a time. The detector is idle after every sixth access, whether or not that access matched a final code.
- R11: The level of `bus_oe_n_i` has no effect on step counting or on the commands.
- R12: A command line rises in the clock cycle right after the edge at which the sixth falling edge of chip enable is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the bus is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ce_n_i | input | 1 | Bus chip enable, active low |
| bus_we_n_i | input | 1 | Bus write enable, active low |
| bus_oe_n_i | input | 1 | Bus output enable, active low (observed, never used) |
| bus_addr_i | input | 16 | Bus address |
| cmd_store_o | output | 1 | One-cycle pulse: commit to nonvolatile storage |
| cmd_recall_o | output | 1 | One-cycle pulse: restore from nonvolatile storage |
| cmd_auto_off_o | output | 1 | One-cycle pulse: disable automatic store |

## Verification
Two functions can act on the same access: breaking a series and starting a new one. A read at the first key address, given at step 2, 3, 4 or 5, does both. The bench sets this up with directed sequences. It also injects the first key at random positions during random series. The step is judged correct when the next four keys plus a final code give exactly the command that the bench model predicts. It is also judged on the cycle of that command, and on the pulse being one cycle wide.

// File: rtl/sud_pkg.sv
package sud_pkg;
  localparam int KEY_W   = 16;
  localparam int PRE_LEN = 5;
  localparam int FIN_LEN = 3;
  localparam int STEPS   = PRE_LEN + 1;

  // fixed prefix, in the order it must be read
  localparam logic [0:PRE_LEN-1][KEY_W-1:0] PRE_KEYS = '{
    16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F
  };
  // final codes; index = command bit (0 store, 1 recall, 2 auto-store off)
  localparam logic [0:FIN_LEN-1][KEY_W-1:0] FIN_KEYS = '{
    16'h8FC0, 16'h4C63, 16'h8B45
  };

  typedef enum logic [1:0] {
    CMD_STORE    = 2'd0,
    CMD_RECALL   = 2'd1,
    CMD_AUTO_OFF = 2'd2
  } cmd_e;
endpackage

// File: rtl/sud_access_edge.sv
module sud_access_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  output logic access_o
);
  logic ce_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_n_q <= 1'b1;
    else         ce_n_q <= ce_n_i;
  end

  assign access_o = ce_n_q & ~ce_n_i;
endmodule

// File: rtl/sud_key_match.sv
module sud_key_match #(
  parameter int ADDR_W   = sud_pkg::KEY_W,
  parameter int MATCH_HI = 14,
  parameter int MATCH_LO = 2,
  parameter int STEP_W   = $clog2(sud_pkg::STEPS)
) (
  input  logic [MATCH_HI:MATCH_LO]  addr_i,
  input  logic [STEP_W-1:0]         step_i,
  output logic                      hit_next_o,
  output logic                      hit_first_o,
  output logic [sud_pkg::FIN_LEN-1:0] fin_hit_o
);
  import sud_pkg::*;

  logic [PRE_LEN-1:0] pre_hit;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_pre
    assign pre_hit[i] = (addr_i == PRE_KEYS[i][MATCH_HI:MATCH_LO]);
  end

  for (genvar j = 0; j < FIN_LEN; j++) begin : g_fin
    assign fin_hit_o[j] = (addr_i == FIN_KEYS[j][MATCH_HI:MATCH_LO]);
  end

  assign hit_first_o = pre_hit[0];
  assign hit_next_o  = (step_i < STEP_W'(PRE_LEN)) ? pre_hit[step_i] : 1'b0;
endmodule

// File: rtl/seq_unlock_detector.sv
module seq_unlock_detector #(
  parameter int ADDR_W   = sud_pkg::KEY_W,
  parameter int MATCH_HI = 14,
  parameter int MATCH_LO = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_ce_n_i,
  input  logic              bus_we_n_i,
  input  logic              bus_oe_n_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              cmd_store_o,
  output logic              cmd_recall_o,
  output logic              cmd_auto_off_o
);
  import sud_pkg::*;

  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic                access;
  logic                hit_next, hit_first;
  logic [FIN_LEN-1:0]  fin_hit;
  logic [STEP_W-1:0]   step_q, step_d;
  logic [FIN_LEN-1:0]  cmd_q, cmd_d;

  // OE level and the uncompared address bits are observed only
  logic unused_bus;
  assign unused_bus = ^{bus_oe_n_i, bus_addr_i[ADDR_W-1:MATCH_HI+1],
                        bus_addr_i[MATCH_LO-1:0]};

  sud_access_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_n_i   (bus_ce_n_i),
    .access_o (access)
  );

  sud_key_match #(
    .ADDR_W   (ADDR_W),
    .MATCH_HI (MATCH_HI),
    .MATCH_LO (MATCH_LO),
    .STEP_W   (STEP_W)
  ) u_match (
    .addr_i      (bus_addr_i[MATCH_HI:MATCH_LO]),
    .step_i      (step_q),
    .hit_next_o  (hit_next),
    .hit_first_o (hit_first),
    .fin_hit_o   (fin_hit)
  );

  always_comb begin
    step_d = step_q;
    cmd_d  = '0;
    if (access) begin
      if (!bus_we_n_i) begin
        step_d = '0;
      end else if (step_q == LAST_STEP) begin
        step_d = '0;
        cmd_d  = fin_hit;
      end else if (hit_next) begin
        step_d = step_q + 1'b1;
      end else if (hit_first) begin
        step_d = STEP_W'(1);    // abort and restart in one access
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      cmd_q  <= '0;
    end else begin
      step_q <= step_d;
      cmd_q  <= cmd_d;
    end
  end

  assign cmd_store_o    = cmd_q[CMD_STORE];
  assign cmd_recall_o   = cmd_q[CMD_RECALL];
  assign cmd_auto_off_o = cmd_q[CMD_AUTO_OFF];

  p_cmd_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_store_o, cmd_recall_o, cmd_auto_off_o}));

  p_cmd_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_store_o | cmd_recall_o | cmd_auto_off_o)
      |=> !(cmd_store_o | cmd_recall_o | cmd_auto_off_o));

  p_idle_after_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_store_o | cmd_recall_o | cmd_auto_off_o) |-> step_q == '0);

  p_hold_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |=> $stable(step_q));

  p_write_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !bus_we_n_i)
      |=> (step_q == '0) && !(cmd_store_o | cmd_recall_o | cmd_auto_off_o));

  p_cmd_from_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_store_o) |-> $past(step_q) == LAST_STEP);
endmodule

// File: tb/seq_unlock_detector_tb.sv
`timescale 1ns/1ps
module seq_unlock_detector_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_ce_n_i = 1'b1;
  logic        bus_we_n_i = 1'b1;
  logic        bus_oe_n_i = 1'b1;
  logic [15:0] bus_addr_i = '0;
  logic        cmd_store_o, cmd_recall_o, cmd_auto_off_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int m_step = 0;

  logic [15:0] tb_pre [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  logic [15:0] tb_fin [3] = '{16'h8FC0, 16'h4C63, 16'h8B45};

  always #2 clk_i = ~clk_i;

  seq_unlock_detector dut_i (
    .clk_i, .rst_ni, .bus_ce_n_i, .bus_we_n_i, .bus_oe_n_i, .bus_addr_i,
    .cmd_store_o, .cmd_recall_o, .cmd_auto_off_o
  );

  function automatic logic [2:0] cmd_vec();
    return {cmd_auto_off_o, cmd_recall_o, cmd_store_o};
  endfunction

  function automatic bit same(input logic [15:0] a, input logic [15:0] b);
    return ((a ^ b) & 16'h7FFC) == 16'h0;
  endfunction

  // reference model, one call per access
  function automatic logic [2:0] model(input logic [15:0] a, input logic we_n);
    logic [2:0] r = '0;
    if (!we_n) m_step = 0;
    else if (m_step == 5) begin
      for (int j = 0; j < 3; j++) if (same(a, tb_fin[j])) r[j] = 1'b1;
      m_step = 0;
    end else if (same(a, tb_pre[m_step])) m_step++;
    else if (same(a, tb_pre[0])) m_step = 1;
    else m_step = 0;
    return r;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cmd=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one access; hold = extra low cycles with address/WE wiggling
  task automatic access(input logic [15:0] a, input logic we_n, input logic oe_n,
                        input int hold, input string req);
    logic [2:0] exp = model(a, we_n);
    @(negedge clk_i);
    bus_ce_n_i = 1'b0; bus_addr_i = a; bus_we_n_i = we_n; bus_oe_n_i = oe_n;
    @(negedge clk_i);
    check(req, cmd_vec(), exp);
    for (int k = 0; k < hold; k++) begin
      bus_addr_i = (k % 2 == 0) ? tb_fin[k % 3] : tb_pre[0];
      bus_we_n_i = $urandom_range(1);
      bus_oe_n_i = $urandom_range(1);
      @(negedge clk_i);
      check("R10 pulse width / R2 held low", cmd_vec(), 3'b000);
    end
    bus_ce_n_i = 1'b1; bus_we_n_i = 1'b1;
    bus_addr_i = 16'($urandom);
    @(negedge clk_i);
    check("R10 pulse width", cmd_vec(), 3'b000);
  endtask

  task automatic prefix(input int upto, input logic [15:0] flip, input string req);
    for (int i = 0; i < upto; i++) access(tb_pre[i] ^ flip, 1'b1, 1'b0, 0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bus_addr_i = 16'($urandom);
      bus_we_n_i = $urandom_range(1);
      @(negedge clk_i);
      check("R2 CE high idle", cmd_vec(), 3'b000);
    end
    bus_we_n_i = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 reset", cmd_vec(), 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", cmd_vec(), 3'b000);

    // R3/R4/R5 basic commands
    prefix(5, 16'h0, "R3 key");
    access(tb_fin[0], 1'b1, 1'b0, 0, "R3 store");
    prefix(5, 16'h0, "R4 key");
    access(tb_fin[1], 1'b1, 1'b1, 0, "R4 recall");
    prefix(5, 16'h0, "R5 key");
    access(tb_fin[2], 1'b1, 1'b0, 0, "R5 auto off");

    // R6 don't-care bits 15,1,0 flipped everywhere
    prefix(5, 16'h8003, "R6 masked key");
    access(tb_fin[0] ^ 16'h8003, 1'b1, 1'b0, 0, "R6 masked store");
    // R6 a compared bit breaks the match
    prefix(5, 16'h0, "R6 key");
    access(tb_fin[1] ^ 16'h0004, 1'b1, 1'b0, 0, "R6 bit2 compared");

    // R7 write at step 4 aborts
    prefix(3, 16'h0, "R7 key");
    access(tb_pre[3], 1'b0, 1'b1, 0, "R7 write abort");
    access(tb_pre[4], 1'b1, 1'b0, 0, "R7 tail");
    access(tb_fin[0], 1'b1, 1'b0, 0, "R7 no cmd");

    // R8 wrong address at step 2, continue the keys
    prefix(1, 16'h0, "R8 key");
    access(16'h1234, 1'b1, 1'b0, 0, "R8 wrong read");
    for (int i = 1; i < 5; i++) access(tb_pre[i], 1'b1, 1'b0, 0, "R8 tail");
    access(tb_fin[1], 1'b1, 1'b0, 0, "R8 no cmd");

    // R9 first key at step 5 restarts the series
    prefix(4, 16'h0, "R9 key");
    access(tb_pre[0], 1'b1, 1'b0, 0, "R9 restart");
    for (int i = 1; i < 5; i++) access(tb_pre[i], 1'b1, 1'b0, 0, "R9 tail");
    access(tb_fin[2], 1'b1, 1'b0, 0, "R9 cmd after restart");

    // R10 sixth access at first key does not restart
    prefix(5, 16'h0, "R10 key");
    access(tb_pre[0], 1'b1, 1'b0, 0, "R10 sixth unmatched");
    for (int i = 1; i < 5; i++) access(tb_pre[i], 1'b1, 1'b0, 0, "R10 tail");
    access(tb_fin[0], 1'b1, 1'b0, 0, "R10 idle after sixth");

    // R2 CE held low and idle gaps, R11 OE toggling
    for (int i = 0; i < 5; i++) begin
      access(tb_pre[i], 1'b1, logic'(i % 2), 3, "R2 held low");
      idle(2);
    end
    access(tb_fin[0], 1'b1, 1'b1, 2, "R11/R12 store, OE high");

    // random series with corruptions
    for (int it = 0; it < 400; it++) begin
      int len = $urandom_range(6, 1);
      for (int s = 0; s < len; s++) begin
        logic [15:0] a;
        logic we = 1'b1;
        int pick = $urandom_range(9);
        a = (s < 5) ? tb_pre[s] : tb_fin[$urandom_range(2)];
        if (pick == 0) a = 16'($urandom);
        else if (pick == 1) a = tb_pre[0];
        else if (pick == 2) we = 1'b0;
        a = a ^ ($urandom_range(1) ? 16'h8000 : 16'h0) ^ 16'($urandom_range(3));
        access(a, we, logic'($urandom_range(1)), $urandom_range(2), "R3-R11 random");
        if ($urandom_range(3) == 0) idle($urandom_range(3, 1));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule